// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block decides which clock domains of a small microcontroller stay running while the CPU sleeps. Software sets a sleep-enable bit and a three-bit mode code; when the CPU then executes its sleep instruction, it raises a one-cycle command pulse. On that pulse the controller records the mode and drops the enables of the selected domains: CPU, non-volatile memory, I/O bus and generated clocks.

While asleep it watches a vector of wake requests, masked by the recorded mode, and a reset request. When a wake is accepted it waits a start-up interval with the clocks still gated, then restores every clock and holds the CPU for a further fixed stall before releasing it. A flag tells the CPU whether to resume via the interrupt path or to start from the reset vector. The external level interrupt passes through a glitch filter that requires a minimum run of consecutive high samples. The block clears no storage on wake.

Top module: `slp_clk_ctrl`

## Requirements
- R1: After reset all four clock enables are 1, `cpu_hold_o` is 0 and `wake_rst_path_o` is 0.
- R2: Sleep is entered on the clock edge where `sleep_cmd_i` and `sleep_en_i` are both 1 while the CPU is running; a command with the enable at 0, or a command while asleep, waking or stalled, changes nothing. `cpu_hold_o` is 1 from entry until the CPU is released.
- R3: Mode 3'b000 stops the CPU and memory clocks only, keeping I/O and generated clocks on; any of the five wake sources wakes it.
- R4: Mode 3'b001 stops the CPU, memory and I/O clocks, keeping generated clocks on; any of the five wake sources wakes it.
- R5: Mode 3'b010 stops all four clocks; wake sources 0 to 3 wake it and source 4 is ignored.
- R6: Mode 3'b011 stops all four clocks; only wake sources 0, 1 and 2 wake it; sources 3 and 4 are ignored.
- R7: Mode codes 3'b100 to 3'b111 behave exactly as mode 3'b000.
- R8: `wake_src_i` bit 0 is the external level interrupt, bit 1 pin change, bit 2 receiver DSP, bit 3 timer, bit 4 other internal events. Bit 0 counts only in the cycle where it has been 1 for `LVL_HOLD` consecutive samples; the other bits count in the cycle they are 1.
- R9: After an accepted wake the gated clocks stay off and the CPU held for `STARTUP_CYC` cycles; then all clocks are on while the CPU is held for `STALL_CYC` (4) more cycles; then `cpu_hold_o` falls.
- R10: `rst_wake_i` during sleep wakes the block through the same sequence and sets `wake_rst_path_o`; it wins over a simultaneous interrupt wake; an interrupt wake leaves the flag 0; entering sleep clears it; the request is ignored while running.
- R11: The mode is captured at entry; changing `sleep_mode_i` while asleep alters neither gating nor wake masking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_en_i | input | 1 | Sleep-enable control bit |
| sleep_mode_i | input | 3 | Sleep mode code |
| sleep_cmd_i | input | 1 | One-cycle pulse: sleep instruction executed |
| wake_src_i | input | 5 | Wake requests, bit map in R8 |
| rst_wake_i | input | 1 | External or watchdog reset request |
| clk_cpu_en_o | output | 1 | CPU clock enable |
| clk_nvm_en_o | output | 1 | Non-volatile memory clock enable |
| clk_io_en_o | output | 1 | I/O bus clock enable |
| clk_gen_en_o | output | 1 | Generated clocks enable |
| cpu_hold_o | output | 1 | CPU held |
| wake_rst_path_o | output | 1 | 1: resume at reset vector, 0: interrupt path |

## Verification
The bench builds the controller with `STARTUP_CYC` = 3 and `LVL_HOLD` = 3 instead of the defaults of 16 and 4. Short start-up lets each wake sequence, including the edge where the stall begins and the edge where the hold drops, be compared cycle by cycle many times within a short run. A three-sample filter makes both the rejected two-cycle glitch and the accepted three-cycle level easy to place against the filter count.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_START = 2'd2,
    ST_STALL = 2'd3
  } slp_state_e;

  typedef struct packed {
    logic cpu;
    logic nvm;
    logic io;
    logic gen;
  } clk_dom_t;

  localparam int WAKE_W   = 5;
  localparam int WK_LVL   = 0;
  localparam int WK_PCHG  = 1;
  localparam int WK_RXDSP = 2;
  localparam int WK_TMR   = 3;
  localparam int WK_MISC  = 4;

  localparam logic [2:0] MD_IDLE = 3'b000;
  localparam logic [2:0] MD_XPS  = 3'b001;
  localparam logic [2:0] MD_PD   = 3'b010;
  localparam logic [2:0] MD_PS   = 3'b011;
endpackage

// File: rtl/slp_mode_decode.sv
module slp_mode_decode
  import slp_pkg::*;
(
  input  logic [2:0]        mode_i,
  output clk_dom_t          stop_o,
  output logic [WAKE_W-1:0] wake_mask_o
);
  logic [2:0] eff_mode;

  // reserved codes fold onto idle so a wake is always reachable
  assign eff_mode = mode_i[2] ? MD_IDLE : mode_i;

  always_comb begin
    stop_o      = '{cpu: 1'b1, nvm: 1'b1, io: 1'b0, gen: 1'b0};
    wake_mask_o = '1;
    unique case (eff_mode)
      MD_XPS: begin
        stop_o.io = 1'b1;
      end
      MD_PD: begin
        stop_o.io            = 1'b1;
        stop_o.gen           = 1'b1;
        wake_mask_o[WK_MISC] = 1'b0;
      end
      MD_PS: begin
        stop_o.io            = 1'b1;
        stop_o.gen           = 1'b1;
        wake_mask_o[WK_MISC] = 1'b0;
        wake_mask_o[WK_TMR]  = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/slp_lvl_filter.sv
module slp_lvl_filter #(
  parameter int HOLD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic ok_o
);
  generate
    if (HOLD <= 1) begin : g_pass
      assign ok_o = raw_i;
    end else begin : g_cnt
      localparam int LW = $clog2(HOLD);
      localparam logic [LW-1:0] LAST = LW'(HOLD - 1);
      logic [LW-1:0] run_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         run_q <= '0;
        else if (!raw_i)     run_q <= '0;
        else if (run_q != LAST) run_q <= run_q + 1'b1;
      end

      assign ok_o = raw_i && (run_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/slp_wake_filter.sv
module slp_wake_filter
  import slp_pkg::*;
#(
  parameter int               LVL_HOLD  = 4,
  parameter logic [WAKE_W-1:0] FILT_MASK = WAKE_W'(1) << WK_LVL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WAKE_W-1:0] raw_i,
  output logic [WAKE_W-1:0] ok_o
);
  for (genvar i = 0; i < WAKE_W; i++) begin : g_src
    if (FILT_MASK[i]) begin : g_flt
      slp_lvl_filter #(.HOLD(LVL_HOLD)) u_flt (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .raw_i (raw_i[i]),
        .ok_o  (ok_o[i])
      );
    end else begin : g_thru
      assign ok_o[i] = raw_i[i];
    end
  end
endmodule

// File: rtl/slp_seq.sv
module slp_seq
  import slp_pkg::*;
#(
  parameter int STARTUP_CYC = 16,
  parameter int STALL_CYC   = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enter_i,
  input  logic       wake_i,
  input  logic       rst_wake_i,
  output slp_state_e state_o,
  output logic       entry_o,
  output logic       rst_path_o
);
  localparam int MAXC = (STARTUP_CYC > STALL_CYC) ? STARTUP_CYC : STALL_CYC;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] START_LAST = CW'(STARTUP_CYC - 1);
  localparam logic [CW-1:0] STALL_LAST = CW'(STALL_CYC - 1);

  slp_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          rst_path_q;

  assign entry_o = (state_q == ST_RUN) && enter_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_RUN;
      cnt_q      <= '0;
      rst_path_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (enter_i) begin
            state_q    <= ST_SLEEP;
            rst_path_q <= 1'b0;
          end
        end
        ST_SLEEP: begin
          if (rst_wake_i || wake_i) begin
            state_q    <= ST_START;
            cnt_q      <= '0;
            rst_path_q <= rst_wake_i;
          end
        end
        ST_START: begin
          if (cnt_q == START_LAST) begin
            state_q <= ST_STALL;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_STALL: begin
          if (cnt_q == STALL_LAST) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign state_o    = state_q;
  assign rst_path_o = rst_path_q;
endmodule

// File: rtl/slp_clk_ctrl.sv
module slp_clk_ctrl
  import slp_pkg::*;
#(
  parameter int STARTUP_CYC = 16,
  parameter int STALL_CYC   = 4,
  parameter int LVL_HOLD    = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_en_i,
  input  logic [2:0] sleep_mode_i,
  input  logic       sleep_cmd_i,
  input  logic [4:0] wake_src_i,
  input  logic       rst_wake_i,
  output logic       clk_cpu_en_o,
  output logic       clk_nvm_en_o,
  output logic       clk_io_en_o,
  output logic       clk_gen_en_o,
  output logic       cpu_hold_o,
  output logic       wake_rst_path_o
);
  slp_state_e        state;
  logic              entry;
  logic [2:0]        mode_q;
  clk_dom_t          stop;
  logic [WAKE_W-1:0] wake_mask;
  logic [WAKE_W-1:0] wake_ok;
  logic              wake_hit;
  logic              gated;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mode_q <= MD_IDLE;
    else if (entry) mode_q <= sleep_mode_i;
  end

  slp_mode_decode u_dec (
    .mode_i     (mode_q),
    .stop_o     (stop),
    .wake_mask_o(wake_mask)
  );

  slp_wake_filter #(.LVL_HOLD(LVL_HOLD)) u_wflt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (wake_src_i),
    .ok_o  (wake_ok)
  );

  assign wake_hit = |(wake_ok & wake_mask);

  slp_seq #(
    .STARTUP_CYC(STARTUP_CYC),
    .STALL_CYC  (STALL_CYC)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enter_i   (sleep_en_i && sleep_cmd_i),
    .wake_i    (wake_hit),
    .rst_wake_i(rst_wake_i),
    .state_o   (state),
    .entry_o   (entry),
    .rst_path_o(wake_rst_path_o)
  );

  // clocks stay gated through start-up; stall runs with everything on
  assign gated        = (state == ST_SLEEP) || (state == ST_START);
  assign clk_cpu_en_o = !(gated && stop.cpu);
  assign clk_nvm_en_o = !(gated && stop.nvm);
  assign clk_io_en_o  = !(gated && stop.io);
  assign clk_gen_en_o = !(gated && stop.gen);
  assign cpu_hold_o   = (state != ST_RUN);
endmodule

// File: rtl/slp_clk_ctrl_chk.sv
module slp_clk_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sleep_en_i,
  input logic       sleep_cmd_i,
  input logic       clk_cpu_en_o,
  input logic       clk_nvm_en_o,
  input logic       clk_io_en_o,
  input logic       clk_gen_en_o,
  input logic       cpu_hold_o,
  input logic       wake_rst_path_o
);
  // R2
  no_spurious_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_hold_o && !(sleep_en_i && sleep_cmd_i)) |=> !cpu_hold_o);

  // R2
  entry_holds_cpu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_hold_o && sleep_en_i && sleep_cmd_i) |=> (cpu_hold_o && !clk_cpu_en_o));

  // R3
  cpu_nvm_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_cpu_en_o == clk_nvm_en_o);

  // R4
  io_off_nests_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_io_en_o |-> !clk_cpu_en_o);

  // R5
  gen_off_nests_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_gen_en_o |-> !clk_io_en_o);

  // R9
  cpu_off_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_cpu_en_o |-> cpu_hold_o);

  // R9
  release_after_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_hold_o) |-> ($past(clk_cpu_en_o) && $past(clk_gen_en_o)));

  // R10
  rst_flag_only_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_rst_path_o) |-> cpu_hold_o);
endmodule

bind slp_clk_ctrl slp_clk_ctrl_chk u_chk (.*);

// File: tb/slp_clk_ctrl_test.sv
`timescale 1ns/1ps
module slp_clk_ctrl_test;
  localparam int STARTUP = 3;
  localparam int STALL   = 4;
  localparam int LVL     = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [2:0] mode = 3'b000;
  logic       cmd = 1'b0;
  logic [4:0] src = '0;
  logic       rreq = 1'b0;
  logic cpu_e, nvm_e, io_e, gen_e, hold, rpath;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  slp_clk_ctrl #(.STARTUP_CYC(STARTUP), .STALL_CYC(STALL), .LVL_HOLD(LVL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_en_i(en), .sleep_mode_i(mode),
    .sleep_cmd_i(cmd), .wake_src_i(src), .rst_wake_i(rreq),
    .clk_cpu_en_o(cpu_e), .clk_nvm_en_o(nvm_e), .clk_io_en_o(io_e),
    .clk_gen_en_o(gen_e), .cpu_hold_o(hold), .wake_rst_path_o(rpath)
  );

  // reference model: phase 0 run, 1 asleep, 2 start-up, 3 stall
  int phase = 0, left = 0, lvl_run = 0;
  logic [2:0] m_mode = 3'b000;
  logic m_rflag = 1'b0;

  function automatic int eff_mode(input logic [2:0] md);
    return md[2] ? 0 : int'(md[1:0]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = 0; left = 0; lvl_run = 0; m_mode = 3'b000; m_rflag = 1'b0;
    end else begin
      bit lvl_ok, wk;
      int em;
      lvl_ok = src[0] && (lvl_run + 1 >= LVL);
      lvl_run = src[0] ? lvl_run + 1 : 0;
      em = eff_mode(m_mode);
      wk = lvl_ok || src[1] || src[2];
      if (em <= 2 && src[3]) wk = 1;
      if (em <= 1 && src[4]) wk = 1;
      case (phase)
        0: if (en && cmd) begin phase = 1; m_mode = mode; m_rflag = 1'b0; end
        1: if (rreq || wk) begin phase = 2; left = STARTUP; m_rflag = rreq; end
        2: begin left--; if (left == 0) begin phase = 3; left = STALL; end end
        default: begin left--; if (left == 0) phase = 0; end
      endcase
    end
  end

  task automatic cmp(input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", cur_req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit stopped;
      int em;
      stopped = (phase == 1) || (phase == 2);
      em = eff_mode(m_mode);
      cmp("cpu_en", cpu_e, !stopped);
      cmp("nvm_en", nvm_e, !stopped);
      cmp("io_en",  io_e,  !(stopped && em != 0));
      cmp("gen_en", gen_e, !(stopped && em >= 2));
      cmp("hold",   hold,  phase != 0);
      cmp("rpath",  rpath, m_rflag);
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      fails++;
      $display("FAIL watchdog R9 act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic go_sleep(input logic [2:0] md);
    en = 1'b1; mode = md; cmd = 1'b1; step(); cmd = 1'b0;
  endtask

  task automatic pulse(input int b);
    src[b] = 1'b1; step(); src = '0;
  endtask

  task automatic expect_asleep(input string tag);
    checks++;
    if (hold !== 1'b1 || phase != 1) begin
      fails++;
      $display("FAIL %s asleep act=%0b exp=1", tag, hold);
    end
  endtask

  initial begin
    #1;
    cur_req = "R1";
    step(2);
    checks++;
    if ({cpu_e, nvm_e, io_e, gen_e, hold, rpath} !== 6'b111100) begin
      fails++;
      $display("FAIL R1 reset act=%b exp=111100", {cpu_e, nvm_e, io_e, gen_e, hold, rpath});
    end
    rst_n = 1'b1;
    step(3);

    cur_req = "R2";
    en = 1'b0; mode = 3'b010; cmd = 1'b1; step(); cmd = 1'b0; step(3);

    cur_req = "R3";
    go_sleep(3'b000); step(3); expect_asleep("R3"); pulse(4); step(12);
    go_sleep(3'b000); step(2); pulse(3); step(12);

    cur_req = "R4";
    go_sleep(3'b001); step(3); pulse(4); step(12);

    cur_req = "R5";
    go_sleep(3'b010); step(2); pulse(4); step(3); expect_asleep("R5"); pulse(1); step(12);

    cur_req = "R6";
    go_sleep(3'b011); step(2); pulse(3); pulse(4); step(3); expect_asleep("R6");
    pulse(2); step(12);

    cur_req = "R7";
    go_sleep(3'b101); step(2); pulse(4); step(12);
    go_sleep(3'b110); step(2); pulse(3); step(12);

    cur_req = "R8";
    go_sleep(3'b011); step(2);
    src[0] = 1'b1; step(2); src[0] = 1'b0; step(4); expect_asleep("R8");
    src[0] = 1'b1; step(4); src[0] = 1'b0; step(12);

    cur_req = "R9";
    go_sleep(3'b001); step(); pulse(0); pulse(1); step(12);

    cur_req = "R10";
    rreq = 1'b1; step(2); rreq = 1'b0; step(2);
    go_sleep(3'b010); step(2); rreq = 1'b1; src[1] = 1'b1; step(); rreq = 1'b0; src = '0;
    step(12);
    go_sleep(3'b000); step(2); pulse(2); step(12);

    cur_req = "R2";
    go_sleep(3'b000); step(); pulse(3); step(STARTUP + 1);
    en = 1'b1; mode = 3'b011; cmd = 1'b1; step(); cmd = 1'b0; step(10);

    cur_req = "R11";
    go_sleep(3'b011); mode = 3'b000; step(2); pulse(4); step(2); expect_asleep("R11");
    pulse(1); step(12);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule